// File: doc/BRIEF.md
# Variable-Read Pixel FIFO

This block buffers a pixel stream between a producer that delivers a fixed group of pixels on every accepted write and a consumer that removes anywhere from zero up to a full group on each cycle. The read side always presents the next group of pixels in stream order. The oldest unread pixel sits in lane 0, and each following lane holds the next younger pixel.

A downstream sliding-window stage uses this to step across image rows whose width is not a multiple of the group size. At the end of a row it takes only the pixels that belong to that row, so the input image needs no padding. A per-lane valid vector and an available-pixel count tell the consumer how much of the presented group is real data.

Top module: `vrfifo`

## Requirements
- R1: After reset, `avail` is 0, `wr_ready` is 1 and every bit of `rd_lane_valid` is 0.
- R2: A write is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. It stores all LANES pixels at once, and lane 0 of `wr_data` (bits W-1:0) is the earliest in stream order.
- R3: `wr_ready` is high exactly when at least LANES pixel slots are free, that is when `avail` <= DEPTH-LANES. A write offered while `wr_ready` is low stores nothing and leaves `avail` unchanged, and `avail` never exceeds DEPTH.
- R4: On each clock edge, the consumer removes `rd_amt` pixels (0 to LANES, never more than `avail`) from the head of the stream. Lane i of `rd_data` (bits i*W+W-1:i*W) always holds the i-th oldest unread pixel.
- R5: When a write and a read occur in the same cycle, `avail` changes by LANES minus `rd_amt` on the next cycle. With no write, it drops by `rd_amt`.
- R6: Bit i of `rd_lane_valid` is 1 exactly when i < `avail`. The valid lanes therefore always form a contiguous run starting at lane 0.
- R7: While `rd_amt` is 0, the pixel in lane 0 stays the same, whether or not writes are accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a pixel group |
| wr_ready | output | 1 | Room for a full pixel group |
| wr_data | input | LANES*W | Pixel group, lane 0 earliest |
| rd_amt | input | $clog2(LANES+1) | Pixels consumed at this edge |
| rd_data | output | LANES*W | Next pixels, lane 0 oldest |
| rd_lane_valid | output | LANES | Per-lane valid for rd_data |
| avail | output | $clog2(DEPTH+1) | Number of stored pixels |

## Verification
The assertions assume that the consumer never asks for more pixels than `avail` reports, and that `rd_amt` never exceeds LANES. Only under those assumptions do the step-by-step count relation and the lane-0 hold property describe legal traffic. Every read amount in the stimulus is drawn from the range 0 to the smaller of LANES and the model's current pixel count, and that count is checked against `avail` every cycle. Writes, by contrast, are offered freely, including while the FIFO is full, because the block is required to ignore them there.

// File: rtl/vrfifo.sv
module vrfifo #(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [LANES*W-1:0]           wr_data,
  input  logic [$clog2(LANES+1)-1:0]   rd_amt,
  output logic [LANES*W-1:0]           rd_data,
  output logic [LANES-1:0]             rd_lane_valid,
  output logic [$clog2(DEPTH+1)-1:0]   avail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, take;
  logic          wr_fire;

  assign wr_fire  = wr_valid && wr_ready;
  assign wr_ready = count <= CW'(DEPTH - LANES);
  assign take     = (CW'(rd_amt) > count) ? count : CW'(rd_amt);
  assign avail    = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + AW'(LANES);
      rd_ptr <= rd_ptr + AW'(take);
      count  <= count + (wr_fire ? CW'(LANES) : CW'(0)) - take;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_fire) mem[AW'(wr_ptr + AW'(i))] <= wr_data[i*W +: W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data[g*W +: W] = mem[AW'(rd_ptr + AW'(g))];
    assign rd_lane_valid[g]  = count > CW'(g);
  end

  AST_RD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_amt) <= int'(count)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(count) == int'($past(count)) + ($past(wr_fire) ? LANES : 0) - int'($past(rd_amt))); // R5
  AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lane_valid & (rd_lane_valid + LANES'(1))) == '0); // R6
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_amt == '0 && count != '0) |=> $stable(rd_data[W-1:0])); // R7
endmodule

// File: tb/vrfifo_bench.sv
`timescale 1ns/1ps
module vrfifo_bench;
  localparam int LANES = 4;
  localparam int W     = 8;
  localparam int DEPTH = 32;
  localparam int RW    = $clog2(LANES+1);
  localparam int CW    = $clog2(DEPTH+1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_valid = 1'b0;
  logic               wr_ready;
  logic [LANES*W-1:0] wr_data = '0;
  logic [RW-1:0]      rd_amt = '0;
  logic [LANES*W-1:0] rd_data;
  logic [LANES-1:0]   rd_lane_valid;
  logic [CW-1:0]      avail;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] model[$];

  always #2.5 clk = ~clk;

  vrfifo #(.LANES(LANES), .W(W), .DEPTH(DEPTH)) u_vrfifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_amt(rd_amt), .rd_data(rd_data),
    .rd_lane_valid(rd_lane_valid), .avail(avail));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic monitor();
    chk("R5 avail", int'(avail), model.size());
    chk("R3 wr_ready", int'(wr_ready), int'(model.size() <= DEPTH - LANES));
    for (int i = 0; i < LANES; i++) begin
      chk("R6 lane valid", int'(rd_lane_valid[i]), int'(i < model.size()));
      if (i < model.size())
        chk("R4 lane data", int'(rd_data[i*W +: W]), int'(model[i]));
    end
  endtask

  task automatic step(bit wv, int ra);
    logic [LANES*W-1:0] d;
    bit fire;
    logic [W-1:0] head;
    d = {$urandom, $urandom};
    wr_valid = wv;
    wr_data  = d;
    rd_amt   = RW'(ra);
    fire = wv && wr_ready;
    head = model.size() > 0 ? model[0] : '0;
    @(posedge clk);
    @(negedge clk);
    repeat (ra) void'(model.pop_front());
    if (fire)
      for (int i = 0; i < LANES; i++) model.push_back(d[i*W +: W]);
    if (ra == 0 && model.size() > 0 && (fire ? model.size() > LANES : 1'b1))
      chk("R7 head held", int'(rd_data[W-1:0]), int'(head));
    monitor();
  endtask

  function automatic int lim();
    return model.size() < LANES ? model.size() : LANES;
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 avail", int'(avail), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 lane valid", int'(rd_lane_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (10) step(1'b1, 0);
    chk("R3 full avail", int'(avail), DEPTH);
    chk("R2 fill order", int'(rd_data[W-1:0]), int'(model[0]));
    step(1'b0, 0);
    for (int a = 1; a <= LANES; a++) step(1'b0, a);
    step(1'b1, 3);
    step(1'b1, LANES);
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, lim()));
    for (int n = 0; n < 2000; n++)
      step($urandom_range(0, 4) == 0, $urandom_range(0, lim()));
    while (model.size() > 0) step(1'b0, lim());
    chk("R1 drained valid", int'(rd_lane_valid), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule